// File: doc/BRIEF.md
# Battery RAM checksum engine

This engine guards a 256-byte battery-backed RAM with a 16-bit integrity word. When started, it walks the data area one byte per cycle through a byte-wide read port that has one cycle of latency. The walk begins at the highest data word and moves down to address 0. Each step rotates the accumulator left by one bit and then adds a 16-bit word modulo 2^16. The word at position p is formed little-endian from the byte pair at p and p+1, so neighbouring words overlap by one byte.

In generate mode, the engine writes the result into the four top bytes of the RAM. It writes the plain word first and then a copy XORed with 0xAAAA. In verify mode, it reads those four bytes back and compares them with the freshly computed value. The `valid` output then tells the system whether the stored contents can be trusted. If they cannot, the system restores its defaults, which happens outside this block.

Top module: `bram_sum_engine`

## Requirements
- R1: While reset is active and whenever the engine is idle, `busy`, `rd_en` and `wr_en` are low. After reset, `done` and `valid` are also low.
- R2: `start` is accepted only when `busy` is low. In the next cycle `busy` is high and `valid` is low. A `start` pulse while `busy` is high has no effect on the mode, the length of the run or what is written.
- R3: The sum starts at 0. For p = 0xFA down to 0, the sum becomes rotl1(sum) + {mem[p+1], mem[p]} modulo 2^16.
- R4: When `gen_mode` = 1 at start (generate), the engine writes exactly four bytes, one per cycle and in this order: 0xFC gets sum[7:0], 0xFD gets sum[15:8], 0xFE gets (sum^0xAAAA)[7:0] and 0xFF gets (sum^0xAAAA)[15:8]. It writes no other address.
- R5: When `gen_mode` = 0 at start (verify), the engine writes nothing. It ends with `valid` = 1 only if all four stored bytes equal the values listed in R4, and with `valid` = 0 otherwise.
- R6: A generate run ends with `valid` = 1.
- R7: `done` is a single-cycle pulse that appears in the same cycle in which `busy` falls. Counting the clock edge that takes `start` as edge 1, `done` follows edge 258 for a generate run and edge 259 for a verify run. `valid` holds its value until the next accepted start.
- R8: Read data is taken on the cycle after `rd_en`. The walk reads addresses 0xFB, 0xFA, … 0x00 in descending order, and `rd_en` and `wr_en` are never high together.
- R9: A `start` in the same cycle as `done` is accepted and begins a new run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (sampled while idle) |
| gen_mode | input | 1 | 1 = generate and store, 0 = verify |
| rd_data | input | 8 | RAM read data, one cycle after `rd_en` |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| valid | output | 1 | Stored check words are consistent |
| rd_en | output | 1 | RAM read request |
| rd_addr | output | 8 | RAM read address |
| wr_en | output | 1 | RAM write strobe |
| wr_addr | output | 8 | RAM write address |
| wr_data | output | 8 | RAM write data |

## Verification
The end-of-run `done` pulse and the acceptance of a new `start` can fall in the same cycle. The bench provokes this by raising `start` at the falling edge at which it first sees `done`, in both generate-then-verify and verify-then-verify orders. The bench judges the overlap by the second run's exact length in cycles and by its `valid` result, so a lost start shows up as a timeout and a double start shows up as a wrong cycle count. The other overlap is a `start` pulse in the middle of a run, which must leave both the run length and the written or unwritten check bytes unchanged.

// File: rtl/bram_sum_pkg.sv
package bram_sum_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD_HI,
        ST_LOAD_LO,
        ST_WALK,
        ST_STORE,
        ST_CHECK
    } seq_state_e;

    function automatic logic [WORD_W-1:0] rotl1(input logic [WORD_W-1:0] v);
        return {v[WORD_W-2:0], v[WORD_W-1]};
    endfunction

endpackage

// File: rtl/bram_sum_accum.sv
module bram_sum_accum
    import bram_sum_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en,
    input  logic [WORD_W-1:0] word,
    output logic [WORD_W-1:0] sum
);

    logic [WORD_W-1:0] sum_d, sum_q;

    always_comb begin
        sum_d = sum_q;
        if (clr) begin
            sum_d = '0;
        end else if (en) begin
            sum_d = rotl1(sum_q) + word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_q <= '0;
        end else begin
            sum_q <= sum_d;
        end
    end

    assign sum = sum_q;

endmodule

// File: rtl/bram_sum_lane.sv
module bram_sum_lane
    import bram_sum_pkg::*;
#(
    parameter logic [WORD_W-1:0] KEY = 16'hAAAA,
    localparam int LANES = 2 * WORD_W / BYTE_W,
    localparam int SEL_W = $clog2(LANES)
) (
    input  logic [WORD_W-1:0] sum,
    input  logic [SEL_W-1:0]  lane_sel,
    output logic [BYTE_W-1:0] lane_byte
);

    logic [2*WORD_W-1:0] pair;

    assign pair      = {sum ^ KEY, sum};
    assign lane_byte = pair[lane_sel*BYTE_W +: BYTE_W];

endmodule

// File: rtl/bram_sum_seq.sv
module bram_sum_seq
    import bram_sum_pkg::*;
#(
    parameter int ADDR_W = 8,
    localparam int LANES = 2 * WORD_W / BYTE_W,
    localparam int SEL_W = $clog2(LANES),
    localparam int IDX_W = $clog2(LANES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              gen_mode,
    input  logic [BYTE_W-1:0] rd_data,
    input  logic [BYTE_W-1:0] lane_byte,
    output logic              busy,
    output logic              done,
    output logic              valid,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              acc_clr,
    output logic              acc_en,
    output logic [WORD_W-1:0] acc_word,
    output logic [SEL_W-1:0]  lane_sel
);

    localparam logic [ADDR_W-1:0] WALK_TOP_A   = ADDR_W'((1 << ADDR_W) - 6);
    localparam logic [ADDR_W-1:0] WALK_HI_A    = ADDR_W'((1 << ADDR_W) - 5);
    localparam logic [ADDR_W-1:0] STORE_BASE_A = ADDR_W'((1 << ADDR_W) - 4);
    localparam logic [IDX_W-1:0]  IDX_LAST     = IDX_W'(LANES - 1);
    localparam logic [IDX_W-1:0]  IDX_END      = IDX_W'(LANES);

    typedef struct packed {
        seq_state_e        st;
        logic [ADDR_W-1:0] pos;
        logic [BYTE_W-1:0] hi;
        logic [IDX_W-1:0]  idx;
        logic              gen;
        logic              bad;
        logic              done;
        logic              valid;
    } seq_t;

    seq_t seq_d, seq_q;
    logic miss;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        rd_en      = 1'b0;
        rd_addr    = '0;
        wr_en      = 1'b0;
        wr_addr    = '0;
        acc_clr    = 1'b0;
        acc_en     = 1'b0;
        lane_sel   = SEL_W'(seq_q.idx);
        miss       = 1'b0;

        case (seq_q.st)
            ST_IDLE: begin
                if (start) begin
                    seq_d.st    = ST_LOAD_HI;
                    seq_d.gen   = gen_mode;
                    seq_d.valid = 1'b0;
                    seq_d.bad   = 1'b0;
                    seq_d.idx   = '0;
                    acc_clr     = 1'b1;
                end
            end

            ST_LOAD_HI: begin
                rd_en    = 1'b1;
                rd_addr  = WALK_HI_A;
                seq_d.st = ST_LOAD_LO;
            end

            ST_LOAD_LO: begin
                seq_d.hi  = rd_data;
                rd_en     = 1'b1;
                rd_addr   = WALK_TOP_A;
                seq_d.pos = WALK_TOP_A;
                seq_d.st  = ST_WALK;
            end

            ST_WALK: begin
                acc_en   = 1'b1;
                seq_d.hi = rd_data;
                if (seq_q.pos == '0) begin
                    seq_d.idx = '0;
                    seq_d.st  = seq_q.gen ? ST_STORE : ST_CHECK;
                end else begin
                    rd_en     = 1'b1;
                    rd_addr   = seq_q.pos - 1'b1;
                    seq_d.pos = seq_q.pos - 1'b1;
                end
            end

            ST_STORE: begin
                wr_en   = 1'b1;
                wr_addr = STORE_BASE_A + ADDR_W'(seq_q.idx);
                if (seq_q.idx == IDX_LAST) begin
                    seq_d.st    = ST_IDLE;
                    seq_d.done  = 1'b1;
                    seq_d.valid = 1'b1;
                end else begin
                    seq_d.idx = seq_q.idx + IDX_W'(1);
                end
            end

            ST_CHECK: begin
                lane_sel  = SEL_W'(seq_q.idx - IDX_W'(1));
                miss      = (seq_q.idx != '0) && (rd_data != lane_byte);
                seq_d.bad = seq_q.bad | miss;
                if (seq_q.idx == IDX_END) begin
                    seq_d.st    = ST_IDLE;
                    seq_d.done  = 1'b1;
                    seq_d.valid = !(seq_q.bad | miss);
                end else begin
                    rd_en     = 1'b1;
                    rd_addr   = STORE_BASE_A + ADDR_W'(seq_q.idx);
                    seq_d.idx = seq_q.idx + IDX_W'(1);
                end
            end

            default: begin
                seq_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign acc_word = {seq_q.hi, rd_data};
    assign busy     = (seq_q.st != ST_IDLE);
    assign done     = seq_q.done;
    assign valid    = seq_q.valid;

endmodule

// File: rtl/bram_sum_engine.sv
module bram_sum_engine
    import bram_sum_pkg::*;
#(
    parameter int                ADDR_W = 8,
    parameter logic [WORD_W-1:0] KEY    = 16'hAAAA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              gen_mode,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              busy,
    output logic              done,
    output logic              valid,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data
);

    localparam int LANES = 2 * WORD_W / BYTE_W;
    localparam int SEL_W = $clog2(LANES);

    logic              acc_clr;
    logic              acc_en;
    logic [WORD_W-1:0] acc_word;
    logic [WORD_W-1:0] sum;
    logic [SEL_W-1:0]  lane_sel;
    logic [BYTE_W-1:0] lane_byte;

    bram_sum_seq #(
        .ADDR_W (ADDR_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .gen_mode  (gen_mode),
        .rd_data   (rd_data),
        .lane_byte (lane_byte),
        .busy      (busy),
        .done      (done),
        .valid     (valid),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .acc_clr   (acc_clr),
        .acc_en    (acc_en),
        .acc_word  (acc_word),
        .lane_sel  (lane_sel)
    );

    bram_sum_accum u_accum (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (acc_clr),
        .en    (acc_en),
        .word  (acc_word),
        .sum   (sum)
    );

    bram_sum_lane #(
        .KEY (KEY)
    ) u_lane (
        .sum       (sum),
        .lane_sel  (lane_sel),
        .lane_byte (lane_byte)
    );

    assign wr_data = lane_byte;

endmodule

// File: rtl/bram_sum_engine_chk.sv
module bram_sum_engine_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              valid,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr
);

    localparam logic [ADDR_W-1:0] HI_A    = ADDR_W'((1 << ADDR_W) - 5);
    localparam logic [ADDR_W-1:0] STORE_A = ADDR_W'((1 << ADDR_W) - 4);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!rd_en && !wr_en));

    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && !valid));

    p_walk_desc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && $past(rd_en) && rd_addr <= HI_A && $past(rd_addr) <= HI_A)
        |-> (rd_addr == $past(rd_addr) - 1'b1));

    p_wr_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_en) |-> (wr_addr == STORE_A));

    p_wr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |-> (wr_addr == $past(wr_addr) + 1'b1));

    p_wr_zone_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_addr >= STORE_A));

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && wr_en));

    p_rerun_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start) |=> busy);

endmodule

bind bram_sum_engine bram_sum_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .valid   (valid),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .wr_en   (wr_en),
    .wr_addr (wr_addr)
);

// File: tb/bram_sum_engine_tb.sv
module bram_sum_engine_tb;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 8;
    localparam int DEPTH      = 1 << ADDR_W;
    localparam int GEN_CYC    = DEPTH + 2;
    localparam int VER_CYC    = DEPTH + 3;
    localparam int RUN_LIMIT  = 2000;
    localparam int NVEC       = 6;

    typedef struct packed {
        logic [7:0] mul;
        logic [7:0] add;
        logic [7:0] flip_addr;
        logic [7:0] flip_mask;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{8'h00, 8'h00, 8'h00, 8'h01},
        '{8'h00, 8'hFF, 8'hFB, 8'h80},
        '{8'h01, 8'h00, 8'h7F, 8'h10},
        '{8'h03, 8'h05, 8'hFC, 8'h01},
        '{8'h07, 8'hA5, 8'hFF, 8'h20},
        '{8'h0D, 8'h33, 8'hFA, 8'hFF}
    };

    logic              clk;
    logic              rst_n;
    logic              start;
    logic              gen_mode;
    logic [7:0]        rd_data;
    logic              busy;
    logic              done;
    logic              valid;
    logic              rd_en;
    logic [ADDR_W-1:0] rd_addr;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [7:0]        wr_data;

    logic              tb_we;
    logic [7:0]        tb_addr;
    logic [7:0]        tb_data;
    logic [7:0]        mem    [DEPTH];
    logic [7:0]        shadow [DEPTH];

    int n_checks;
    int n_errors;

    bram_sum_engine u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .gen_mode (gen_mode),
        .rd_data  (rd_data),
        .busy     (busy),
        .done     (done),
        .valid    (valid),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data)
    );

    initial begin
        clk = 1'b0;
        forever #(CLK_PERIOD / 2) clk = ~clk;
    end

    always @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
        else if (tb_we) mem[tb_addr] <= tb_data;
        if (rd_en) rd_data <= mem[rd_addr];
    end

    function automatic logic [15:0] model_sum();
        logic [15:0] acc = 16'h0000;
        for (int p = DEPTH - 6; p >= 0; p--) begin
            acc = {acc[14:0], acc[15]} + {shadow[p+1], shadow[p]};
        end
        return acc;
    endfunction

    function automatic bit model_ok();
        logic [15:0] s = model_sum();
        logic [15:0] m = s ^ 16'hAAAA;
        return shadow[DEPTH-4] == s[7:0] && shadow[DEPTH-3] == s[15:8] &&
               shadow[DEPTH-2] == m[7:0] && shadow[DEPTH-1] == m[15:8];
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic poke(input logic [7:0] a, input logic [7:0] d);
        tb_we     = 1'b1;
        tb_addr   = a;
        tb_data   = d;
        shadow[a] = d;
        @(posedge clk);
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    task automatic fill(input logic [7:0] mul, input logic [7:0] add);
        for (int p = 0; p < DEPTH; p++) begin
            poke(8'(p), 8'(mul * 8'(p) + add));
        end
    endtask

    task automatic run(input bit gen, input int poke_at, output int cycles);
        int cnt;
        start    = 1'b1;
        gen_mode = gen;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        cnt   = 1;
        chk(busy && !valid, "R2 busy set and valid cleared after start",
            32'({busy, valid}), 32'(2'b10));
        while (!done && cnt < RUN_LIMIT) begin
            if (cnt == poke_at) begin
                start    = 1'b1;
                gen_mode = !gen;
            end else begin
                start = 1'b0;
            end
            @(posedge clk);
            @(negedge clk);
            cnt++;
        end
        start = 1'b0;
        if (cnt >= RUN_LIMIT) chk(1'b0, "R7 run watchdog", cnt, RUN_LIMIT);
        cycles = cnt;
    endtask

    task automatic check_store(input string tag);
        logic [15:0] s = model_sum();
        logic [15:0] m = s ^ 16'hAAAA;
        chk(mem[DEPTH-4] == s[7:0],  {tag, " sum low at 0xFC"},  32'(mem[DEPTH-4]), 32'(s[7:0]));
        chk(mem[DEPTH-3] == s[15:8], {tag, " sum high at 0xFD"}, 32'(mem[DEPTH-3]), 32'(s[15:8]));
        chk(mem[DEPTH-2] == m[7:0],  {tag, " mirror low at 0xFE"},  32'(mem[DEPTH-2]), 32'(m[7:0]));
        chk(mem[DEPTH-1] == m[15:8], {tag, " mirror high at 0xFF"}, 32'(mem[DEPTH-1]), 32'(m[15:8]));
        shadow[DEPTH-4] = s[7:0];
        shadow[DEPTH-3] = s[15:8];
        shadow[DEPTH-2] = m[7:0];
        shadow[DEPTH-1] = m[15:8];
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_errors++;
        $display("FAIL global watchdog expired actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        int c;
        bit exp_ok;
        logic [7:0] a;
        n_checks = 0;
        n_errors = 0;
        rst_n    = 1'b0;
        start    = 1'b0;
        gen_mode = 1'b0;
        tb_we    = 1'b0;
        tb_addr  = '0;
        tb_data  = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!busy && !done && !valid && !rd_en && !wr_en, "R1 outputs low in reset",
            32'({busy, done, valid, rd_en, wr_en}), 0);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk(!busy && !done && !valid && !rd_en && !wr_en, "R1 outputs low after reset",
            32'({busy, done, valid, rd_en, wr_en}), 0);

        for (int v = 0; v < NVEC; v++) begin
            fill(VECS[v].mul, VECS[v].add);
            run(1'b1, 0, c);
            chk(c == GEN_CYC, "R7 generate run length", c, GEN_CYC);
            chk(valid, "R6 valid after generate", 32'(valid), 1);
            check_store("R3 R4");
            run(1'b0, 0, c);
            chk(c == VER_CYC, "R7 verify run length", c, VER_CYC);
            chk(valid, "R5 verify of fresh words", 32'(valid), 1);
            repeat (v) @(negedge clk);
            a = VECS[v].flip_addr;
            poke(a, shadow[a] ^ VECS[v].flip_mask);
            exp_ok = model_ok();
            run(1'b0, 0, c);
            chk(valid == exp_ok, "R5 verify after corruption", 32'(valid), 32'(exp_ok));
            chk(mem[a] == shadow[a], "R5 verify leaves RAM unwritten", 32'(mem[a]), 32'(shadow[a]));
        end

        poke(8'(DEPTH - 4), ~shadow[DEPTH-4]);
        run(1'b1, 20, c);
        chk(c == GEN_CYC, "R2 start while busy keeps generate length", c, GEN_CYC);
        check_store("R2 start while busy keeps generate writes");

        poke(8'(DEPTH - 3), shadow[DEPTH-3] ^ 8'h04);
        run(1'b0, 30, c);
        chk(c == VER_CYC, "R2 start while busy keeps verify length", c, VER_CYC);
        chk(!valid, "R2 verify stays verify", 32'(valid), 0);
        chk(mem[DEPTH-3] == shadow[DEPTH-3], "R2 no write after ignored start",
            32'(mem[DEPTH-3]), 32'(shadow[DEPTH-3]));

        run(1'b1, 0, c);
        check_store("R9 generate before chained start");
        run(1'b0, 0, c);
        chk(c == VER_CYC, "R9 start in done cycle runs verify", c, VER_CYC);
        chk(valid, "R9 chained verify result", 32'(valid), 1);
        run(1'b0, 0, c);
        chk(c == VER_CYC, "R9 second chained verify", c, VER_CYC);

        @(posedge clk);
        @(negedge clk);
        chk(!done && !busy, "R7 done lasts one cycle", 32'({done, busy}), 0);
        repeat (4) @(negedge clk);
        chk(valid, "R7 valid held while idle", 32'(valid), 1);

        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule